// File: doc/BRIEF.md
# Per-Core Coded Chunk Decoder

This block sits beside one core's private cache in a multicore system whose caches were filled ahead of time so that every core holds, for every application, the one slice of data that is tagged with its own core index. When cores miss, a shared bus carries chunks. Each chunk is the bitwise XOR of two slices, each needed by one of a pair of cores, and it carries a membership mask that names the two cores. Each chunk is sent as a burst of beats, and the beat index comes with the data.

For every chunk whose pair includes this core, the decoder finds the partner core in the mask. It then reads the partner's interfering slice from the local cache, using the application the partner has requested and the beat index. It XORs that word out of the received beat and writes the result into a local buffer of missing data. Chunks for other pairs cost nothing: no cache read and no buffer write. The decoder records which partner slots have been fully recovered and raises a done flag once every partner has delivered its chunk. A start pulse opens a new delivery period by latching the request vector of all cores.

Top module: `coded_chunk_decoder`

## Requirements
- R1: After reset, `done_o`, `cache_rd_en_o` and `buf_wr_en_o` are all low.
- R2: A bus beat is accepted only when `bus_mask_i` has bit `CORE_ID` set and exactly two bits set in total. Any other mask (zero, one other core, three or more cores) causes no cache read, no buffer write and no change to `done_o`.
- R3: For an accepted beat, a cache read is issued in the same cycle at address `req[p]*BEATS + beat`, where `p` is the other core in the mask and `req[p]` is that core's latched application index.
- R4: One cycle after an accepted beat, `buf_wr_en_o` is high and `buf_wr_data_o` equals the beat data XOR the cache word returned for the read of R3. This is this core's own requested slice for that beat.
- R5: The buffer address is `slot*BEATS + beat`, where `slot = p` when `p < CORE_ID` and `slot = p-1` otherwise. The slots therefore cover the K-1 partners in ascending core order.
- R6: Beats of consecutive cycles are each decoded, one buffer write per cycle, with no gap.
- R7: A partner slot counts as recovered when its beat `BEATS-1` is written. `done_o` rises one cycle after the write that completes the last unrecovered of the K-1 slots. A repeated chunk for a slot that is already recovered does not advance completion.
- R8: A cycle with `start_i` high latches `req_i` (core i's application in bits `[i*APP_W +: APP_W]`), clears all recovered slots and drives `done_o` low from the next cycle. `done_o` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a delivery period; latches the requests |
| req_i | input | NUM_CORES*APP_W | Requested application of every core |
| bus_valid_i | input | 1 | Broadcast beat present |
| bus_mask_i | input | NUM_CORES | Core-membership mask of the chunk |
| bus_beat_i | input | BEAT_W | Beat index within the chunk |
| bus_data_i | input | DATA_W | Coded beat data |
| cache_rd_en_o | output | 1 | Local cache read strobe |
| cache_rd_addr_o | output | CADDR_W | Local cache read address |
| cache_rd_data_i | input | DATA_W | Cache word, one cycle after the strobe |
| buf_wr_en_o | output | 1 | Missing-data buffer write strobe |
| buf_wr_addr_o | output | BADDR_W | Buffer slot and beat address |
| buf_wr_data_o | output | DATA_W | Recovered data |
| done_o | output | 1 | All partner slots recovered this period |

## Verification
The bench runs two delivery periods with different request vectors, so the cache addresses and the recovered words change with the mapping from core to application. One period has two cores asking for the same application. All six pair masks are broadcast, and a partner below and a partner above this core's index check the slot mapping. The zero, three-bit and four-bit masks that must be dropped are also sent. The second period repeats one chunk before the set is complete, which separates counting chunks from tracking slots. It also checks that the start pulse drops a `done_o` that was high.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

   // Buffer slot of a partner core: partners are packed in ascending order,
   // skipping the owning core.
   function automatic int unsigned partner_slot(input int unsigned partner,
                                                input int unsigned owner);
      return (partner < owner) ? partner : partner - 1;
   endfunction

endpackage

// File: rtl/ccd_mask_decode.sv
module ccd_mask_decode #(
   parameter int NUM_CORES = 4,
   parameter int CORE_ID   = 0,
   localparam int PW       = $clog2(NUM_CORES),
   localparam int SW       = $clog2(NUM_CORES - 1)
) (
   input  logic [NUM_CORES-1:0] mask_i,
   output logic                 hit_o,
   output logic [PW-1:0]        partner_o,
   output logic [SW-1:0]        slot_o
);
   import ccd_pkg::*;

   logic pair_ok;

   assign pair_ok = ($countones(mask_i) == 2);
   assign hit_o   = mask_i[CORE_ID] && pair_ok;

   always_comb begin
      partner_o = '0;
      slot_o    = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (mask_i[i] && (i != CORE_ID)) begin
            partner_o = PW'(i);
            slot_o    = SW'(partner_slot(i, CORE_ID));
         end
      end
   end

endmodule

// File: rtl/ccd_xor_stage.sv
module ccd_xor_stage #(
   parameter int DATA_W  = 128,
   parameter int BADDR_W = 4,
   parameter int SW      = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic [DATA_W-1:0]  data_i,
   input  logic [BADDR_W-1:0] addr_i,
   input  logic               last_i,
   input  logic [SW-1:0]      slot_i,
   input  logic [DATA_W-1:0]  cache_data_i,
   output logic               wr_en_o,
   output logic [BADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0]  wr_data_o,
   output logic               wr_last_o,
   output logic [SW-1:0]      wr_slot_o
);

   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         data_q    <= '0;
         wr_last_o <= 1'b0;
         wr_slot_o <= '0;
      end else begin
         wr_en_o <= take_i;
         if (take_i) begin
            wr_addr_o <= addr_i;
            data_q    <= data_i;
            wr_last_o <= last_i;
            wr_slot_o <= slot_i;
         end
      end
   end

   // Cache word returns in this cycle and cancels the partner's term.
   assign wr_data_o = data_q ^ cache_data_i;

endmodule

// File: rtl/ccd_progress.sv
module ccd_progress #(
   parameter int SLOTS = 3,
   localparam int SW   = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          mark_i,
   input  logic [SW-1:0] mark_slot_i,
   output logic          done_o
);

   logic [SLOTS-1:0] recovered_q;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  recovered_q[g] <= 1'b0;
         else if (clear_i)                            recovered_q[g] <= 1'b0;
         else if (mark_i && (mark_slot_i == SW'(g)))  recovered_q[g] <= 1'b1;
      end
   end

   assign done_o = &recovered_q;

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !clear_i |=> done_o);

   // R8
   done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_o) |-> $past(clear_i));

endmodule

// File: rtl/coded_chunk_decoder.sv
module coded_chunk_decoder #(
   parameter int NUM_CORES = 4,
   parameter int NUM_APPS  = 4,
   parameter int SUBSET_T  = 1,
   parameter int BEATS     = 4,
   parameter int DATA_W    = 128,
   parameter int CORE_ID   = 0,
   localparam int APP_W    = $clog2(NUM_APPS),
   localparam int BEAT_W   = $clog2(BEATS),
   localparam int SLOTS    = NUM_CORES - 1,
   localparam int SW       = $clog2(SLOTS),
   localparam int PW       = $clog2(NUM_CORES),
   localparam int CADDR_W  = $clog2(NUM_APPS * BEATS),
   localparam int BADDR_W  = $clog2(SLOTS * BEATS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [NUM_CORES*APP_W-1:0] req_i,
   input  logic                       bus_valid_i,
   input  logic [NUM_CORES-1:0]       bus_mask_i,
   input  logic [BEAT_W-1:0]          bus_beat_i,
   input  logic [DATA_W-1:0]          bus_data_i,
   output logic                       cache_rd_en_o,
   output logic [CADDR_W-1:0]         cache_rd_addr_o,
   input  logic [DATA_W-1:0]          cache_rd_data_i,
   output logic                       buf_wr_en_o,
   output logic [BADDR_W-1:0]         buf_wr_addr_o,
   output logic [DATA_W-1:0]          buf_wr_data_o,
   output logic                       done_o
);

   if (SUBSET_T != 1) begin : g_bad_t
      $error("coded_chunk_decoder: only pairwise chunks (SUBSET_T == 1) are decoded");
   end
   if (NUM_CORES < 3 || CORE_ID < 0 || CORE_ID >= NUM_CORES) begin : g_bad_core
      $error("coded_chunk_decoder: need NUM_CORES >= 3 and CORE_ID inside it");
   end
   if (NUM_APPS < 2 || BEATS < 2 || DATA_W < 1) begin : g_bad_size
      $error("coded_chunk_decoder: NUM_APPS and BEATS must be at least 2");
   end

   logic [APP_W-1:0] req_q [NUM_CORES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CORES; i++) req_q[i] <= '0;
      end else if (start_i) begin
         for (int i = 0; i < NUM_CORES; i++) req_q[i] <= req_i[i*APP_W +: APP_W];
      end
   end

   logic          hit;
   logic [PW-1:0] partner;
   logic [SW-1:0] slot;
   logic          take;
   logic          last_beat;
   logic [BADDR_W-1:0] buf_addr;
   logic          wr_last;
   logic [SW-1:0] wr_slot;

   ccd_mask_decode #(.NUM_CORES(NUM_CORES), .CORE_ID(CORE_ID)) u_mask (
      .mask_i    (bus_mask_i),
      .hit_o     (hit),
      .partner_o (partner),
      .slot_o    (slot)
   );

   assign take      = bus_valid_i && hit;
   assign last_beat = (bus_beat_i == BEAT_W'(BEATS - 1));
   assign buf_addr  = BADDR_W'(slot) * BADDR_W'(BEATS) + BADDR_W'(bus_beat_i);

   // Read issued with the beat; data returns as the beat leaves the stage.
   assign cache_rd_en_o   = take;
   assign cache_rd_addr_o = CADDR_W'(req_q[partner]) * CADDR_W'(BEATS)
                          + CADDR_W'(bus_beat_i);

   ccd_xor_stage #(.DATA_W(DATA_W), .BADDR_W(BADDR_W), .SW(SW)) u_xor (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .data_i       (bus_data_i),
      .addr_i       (buf_addr),
      .last_i       (last_beat),
      .slot_i       (slot),
      .cache_data_i (cache_rd_data_i),
      .wr_en_o      (buf_wr_en_o),
      .wr_addr_o    (buf_wr_addr_o),
      .wr_data_o    (buf_wr_data_o),
      .wr_last_o    (wr_last),
      .wr_slot_o    (wr_slot)
   );

   ccd_progress #(.SLOTS(SLOTS)) u_prog (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (start_i),
      .mark_i      (buf_wr_en_o && wr_last),
      .mark_slot_i (wr_slot),
      .done_o      (done_o)
   );

   // R2
   drop_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_rd_en_o |-> bus_valid_i && bus_mask_i[CORE_ID]);

   // R4
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en_o |-> $past(cache_rd_en_o));

   // R6
   back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_rd_en_o |=> buf_wr_en_o);

   // R5
   buf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en_o |-> (int'(buf_wr_addr_o) < SLOTS * BEATS));

endmodule

// File: tb/coded_chunk_decoder_tb.sv
`timescale 1ns/1ps
module coded_chunk_decoder_tb;

   localparam int K = 4, N = 4, BEATS = 4, DW = 128, CORE = 1;
   localparam int APP_W = 2, BEAT_W = 2, CADDR_W = 4, BADDR_W = 4;

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic [K*APP_W-1:0] req_i = '0;
   logic bus_valid_i = 1'b0;
   logic [K-1:0] bus_mask_i = '0;
   logic [BEAT_W-1:0] bus_beat_i = '0;
   logic [DW-1:0] bus_data_i = '0;
   logic cache_rd_en_o;
   logic [CADDR_W-1:0] cache_rd_addr_o;
   logic [DW-1:0] cache_rd_data_i = '0;
   logic buf_wr_en_o;
   logic [BADDR_W-1:0] buf_wr_addr_o;
   logic [DW-1:0] buf_wr_data_o;
   logic done_o;

   always #2.5 clk = ~clk;

   coded_chunk_decoder #(.NUM_CORES(K), .NUM_APPS(N), .SUBSET_T(1), .BEATS(BEATS),
                         .DATA_W(DW), .CORE_ID(CORE)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
      .bus_valid_i(bus_valid_i), .bus_mask_i(bus_mask_i), .bus_beat_i(bus_beat_i),
      .bus_data_i(bus_data_i), .cache_rd_en_o(cache_rd_en_o),
      .cache_rd_addr_o(cache_rd_addr_o), .cache_rd_data_i(cache_rd_data_i),
      .buf_wr_en_o(buf_wr_en_o), .buf_wr_addr_o(buf_wr_addr_o),
      .buf_wr_data_o(buf_wr_data_o), .done_o(done_o));

   int tests = 0, fails = 0;
   int req [K];
   logic exp_rd = 1'b0;
   logic [BADDR_W-1:0] q_addr [$];
   logic [DW-1:0]      q_data [$];

   // Slice of application app stored under core index j, beat b.
   function automatic logic [DW-1:0] slice(input int app, input int j, input int b);
      logic [31:0] w;
      w = (32'(app) * 32'h0100_0193) ^ (32'(j + 1) * 32'h9E37_79B9)
        ^ (32'(b + 3) * 32'h85EB_CA6B) ^ 32'h0123_4567;
      return {w, ~w, w ^ 32'hA5A5_A5A5, {w[15:0], w[31:16]}};
   endfunction

   // Local cache model of this core: one-cycle read latency.
   always @(posedge clk)
      if (cache_rd_en_o)
         cache_rd_data_i <= slice(int'(cache_rd_addr_o) / BEATS, CORE,
                                  int'(cache_rd_addr_o) % BEATS);

   // Monitor: pops the scoreboard as writes appear.
   always @(negedge clk) begin
      if (rst_n && bus_valid_i) begin
         tests++;
         if (cache_rd_en_o !== exp_rd) begin
            fails++;
            $display("FAIL R2/R3 read strobe mask=%b: got %b exp %b", bus_mask_i, cache_rd_en_o, exp_rd);
         end
      end
      if (rst_n && buf_wr_en_o) begin
         tests++;
         if (q_addr.size() == 0) begin
            fails++;
            $display("FAIL R2 unexpected write addr=%0d: got 1 exp 0", buf_wr_addr_o);
         end else begin
            logic [BADDR_W-1:0] ea;
            logic [DW-1:0] ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            if (buf_wr_addr_o !== ea || buf_wr_data_o !== ed) begin
               fails++;
               $display("FAIL R4/R5 write: got addr=%0d data=%h exp addr=%0d data=%h",
                        buf_wr_addr_o, buf_wr_data_o, ea, ed);
            end
         end
      end
   end

   task automatic check(input string tag, input logic got, input logic exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b exp %b", tag, got, exp);
      end
   endtask

   task automatic set_period(input int r0, input int r1, input int r2, input int r3);
      @(posedge clk); #1;
      req[0] = r0; req[1] = r1; req[2] = r2; req[3] = r3;
      req_i = {APP_W'(r3), APP_W'(r2), APP_W'(r1), APP_W'(r0)};
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
   endtask

   // Driver: sends one chunk back to back and queues the expected writes.
   task automatic send_chunk(input logic [K-1:0] mask);
      int s;
      bit hit;
      s = -1;
      for (int i = 0; i < K; i++) if (mask[i] && i != CORE) s = i;
      hit = mask[CORE] && ($countones(mask) == 2);
      for (int b = 0; b < BEATS; b++) begin
         @(posedge clk); #1;
         bus_valid_i = 1'b1;
         bus_mask_i  = mask;
         bus_beat_i  = BEAT_W'(b);
         exp_rd      = hit;
         if (s >= 0)
            bus_data_i = slice(req[CORE], s, b) ^ slice(req[s], CORE, b);
         else
            bus_data_i = slice(b, 7, b);
         if (hit) begin
            q_addr.push_back(BADDR_W'(((s < CORE) ? s : s - 1) * BEATS + b));
            q_data.push_back(slice(req[CORE], s, b));
         end
      end
      @(posedge clk); #1;
      bus_valid_i = 1'b0;
      exp_rd = 1'b0;
   endtask

   task automatic check_done(input string tag, input logic exp);
      @(posedge clk);
      @(negedge clk);
      check(tag, done_o, exp);
   endtask

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: got timeout exp finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 done after reset", done_o, 1'b0);
      check("R1 read after reset", cache_rd_en_o, 1'b0);
      check("R1 write after reset", buf_wr_en_o, 1'b0);
      #1 rst_n = 1'b1;

      // Period 1: cores ask for apps 0,1,2,3.
      set_period(0, 1, 2, 3);
      check_done("R8 done after first start", 1'b0);
      send_chunk(4'b0011);                 // R3 R5 partner 0, slot 0
      send_chunk(4'b0101);                 // R2 dropped
      send_chunk(4'b0110);                 // partner 2, slot 1
      check_done("R7 done with two of three slots", 1'b0);
      send_chunk(4'b1001);                 // R2 dropped
      send_chunk(4'b1100);                 // R2 dropped
      send_chunk(4'b1010);                 // R6 partner 3, slot 2
      check_done("R7 done after last slot", 1'b1);
      send_chunk(4'b0000);                 // R2 empty mask
      send_chunk(4'b0111);                 // R2 three cores
      check_done("R2 done unchanged by dropped chunks", 1'b1);

      // Period 2: cores 2 and 3 share an application.
      set_period(3, 2, 0, 0);
      check("R8 done cleared by start", done_o, 1'b0);
      send_chunk(4'b1010);
      send_chunk(4'b1010);                 // R7 duplicate slot
      send_chunk(4'b0011);
      check_done("R7 duplicate does not complete", 1'b0);
      send_chunk(4'b1111);                 // R2 four cores
      send_chunk(4'b0110);
      check_done("R7 done in second period", 1'b1);

      repeat (2) @(posedge clk);
      tests++;
      if (q_addr.size() != 0) begin
         fails++;
         $display("FAIL R4 missing writes: got %0d pending exp 0", q_addr.size());
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule